// File: doc/BRIEF.md
# Flip-Flop Chain Upset Checker

This block supervises a bank of shift register chains that serve as upset detectors in a radiation test. It produces one pattern bit that feeds the input of every chain, and it drives the clear lines those chains use. Chains in four clear styles can hang off it: no clear, a synchronous clear, an asynchronous clear taken straight from the external reset, and a clear that asserts asynchronously and releases on the clock. The pattern can be all zeros, all ones, or a checkerboard that toggles every clock.

The block rebuilds locally the bit it expects at each chain output, taking the chain depth into account, and compares it with what every chain returns. It keeps quiet while the chains fill after reset or after a pattern change. Each mismatching cycle produces one message with a valid/ready handshake. The message carries the timestamp of the detection cycle, a running count of 0-to-1 flips and a separate running count of 1-to-0 flips, a mask of the chains that disagreed, and the flip direction. When the consumer stalls, the counters keep counting and a sticky flag records that a message was lost.

Top module: `upset_chain_checker`

## Requirements
- R1: While `rst_n` is low, `msg_valid` and `msg_lost` are 0, `chain_srst` is 1 and `chain_arsr_n` is 0. `chain_arsr_n` rises, and `chain_srst` falls, on the second rising clock edge after `rst_n` goes high.
- R2: `pat_sel` encodes the pattern. 2'b00 drives `chain_din` to 0, 2'b01 drives it to 1, and 2'b10 or 2'b11 makes it invert on every clock. A new `pat_sel` value reaches `chain_din` one clock later.
- R3: No message is produced until CHAIN_LEN clocks after internal reset release, or after a change of `pat_sel`, so data from the fill never counts as an upset.
- R4: Once the chains are full, a cycle in which any `chain_dout` bit differs from the `chain_din` value of CHAIN_LEN clocks earlier produces a message on the next cycle. In that message, bit i of `msg_mask` is set for each chain i that differed.
- R5: `msg_dir` is 1 for a 0-to-1 upset (expected 0, observed 1) and 0 for a 1-to-0 upset.
- R6: `msg_cnt_rise` and `msg_cnt_fall` are running totals of flipped bits since reset, kept separately by direction. They include the flips of the message's own cycle.
- R7: `msg_time` is a free-running clock counter sampled in the detection cycle. Two messages detected N cycles apart differ in `msg_time` by N.
- R8: While `msg_valid` is 1 and `msg_ready` is 0, every message field holds its value.
- R9: A mismatch that arrives while a message is stalled is not queued. It still adds to the counters, and it sets `msg_lost`, which stays 1 until reset.
- R10: A mismatch in the same cycle that a message is accepted loads a new message. `msg_valid` stays 1 and `msg_lost` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| pat_sel | input | 2 | Pattern choice: 00 zeros, 01 ones, 1x checkerboard |
| chain_dout | input | NUM_CHAINS | Last-stage output of each chain |
| msg_ready | input | 1 | Consumer accepts the message |
| chain_din | output | 1 | Pattern bit fed to every chain input |
| chain_srst | output | 1 | Synchronous clear for chains of that style, active high |
| chain_arsr_n | output | 1 | Clear with asynchronous assert and clocked release, active low |
| msg_valid | output | 1 | Message present |
| msg_time | output | TS_W | Timestamp of the detection cycle |
| msg_cnt_rise | output | CNT_W | Running count of 0-to-1 flips |
| msg_cnt_fall | output | CNT_W | Running count of 1-to-0 flips |
| msg_mask | output | NUM_CHAINS | Chains that disagreed |
| msg_dir | output | 1 | 1 = 0-to-1 upset, 0 = 1-to-0 upset |
| msg_lost | output | 1 | Sticky flag: a message was dropped during a stall |

## Verification
Two functions can fall in the same cycle. A new mismatch can arrive in the cycle the consumer accepts the current message, and a new mismatch can arrive while the consumer is stalled. The bench provokes both by raising `msg_ready` on the same clock in which it flips a chain output, and by injecting a second flip while holding `msg_ready` low. It then judges that the first case gives a fresh message without `msg_lost`. In the second case it checks that the held message is unchanged, that `msg_lost` is set, and that the dropped flip still appears in the counts of the next delivered message.

// File: rtl/upchk_pkg.sv
package upchk_pkg;

  // Bit driven into the chains for a pattern choice and checkerboard phase.
  function automatic logic drive_bit(input logic [1:0] sel, input logic phase);
    return sel[1] ? phase : sel[0];
  endfunction

  // Bit expected at a chain output of depth len: the drive bit len clocks ago.
  function automatic logic expect_bit(input logic [1:0] sel, input logic phase,
                                      input int unsigned len);
    return sel[1] ? (phase ^ len[0]) : sel[0];
  endfunction

endpackage

// File: rtl/upchk_rst_sync.sv
module upchk_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage1;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1 <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      stage1 <= 1'b1;
      srst_n <= stage1;
    end
  end

  // R1: release takes two clock edges after the external reset rises
  p_release_r1: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(srst_n) |-> $past(stage1));
endmodule

// File: rtl/upchk_stream_ref.sv
module upchk_stream_ref #(
  parameter int unsigned CHAIN_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pat_sel,
  output logic       din,
  output logic       exp_bit,
  output logic       cmp_en
);
  import upchk_pkg::*;

  localparam int unsigned FW = $clog2(CHAIN_LEN + 1);
  localparam logic [FW-1:0] FULL = FW'(CHAIN_LEN);

  logic [1:0]    pat_q;
  logic          phase;
  logic [FW-1:0] fill;
  logic          pat_change;

  assign pat_change = (pat_sel != pat_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= 2'b00;
      phase <= 1'b0;
      fill  <= '0;
    end else begin
      pat_q <= pat_sel;
      phase <= ~phase;
      if (pat_change)
        fill <= '0;
      else if (fill != FULL)
        fill <= fill + 1'b1;
    end
  end

  assign din     = drive_bit(pat_q, phase);
  assign exp_bit = expect_bit(pat_q, phase, CHAIN_LEN);
  assign cmp_en  = (fill == FULL);

  // R3: a pattern change always closes the compare window
  p_refill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pat_change |=> !cmp_en);

  // R2: checkerboard toggles every clock while it stays selected
  p_checker_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_q[1] && $past(pat_q[1])) |-> (din != $past(din)));

  // R2: solid patterns hold steady
  p_solid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pat_q[1] && $past(pat_q) == pat_q) |-> $stable(din));
endmodule

// File: rtl/upchk_log.sv
module upchk_log #(
  parameter int unsigned NUM_CHAINS = 12,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned TS_W       = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CHAINS-1:0] hit_mask,
  input  logic                  exp_bit,
  input  logic [TS_W-1:0]       ts,
  input  logic                  msg_ready,
  output logic                  msg_valid,
  output logic [TS_W-1:0]       msg_time,
  output logic [CNT_W-1:0]      msg_cnt_rise,
  output logic [CNT_W-1:0]      msg_cnt_fall,
  output logic [NUM_CHAINS-1:0] msg_mask,
  output logic                  msg_dir,
  output logic                  msg_lost
);
  logic             hit, up_evt, dn_evt, load, drop;
  logic [CNT_W-1:0] nbits, rise_q, fall_q, rise_nx, fall_nx;

  assign hit     = |hit_mask;
  assign up_evt  = hit & ~exp_bit;
  assign dn_evt  = hit &  exp_bit;
  assign nbits   = CNT_W'($countones(hit_mask));
  assign rise_nx = rise_q + (up_evt ? nbits : '0);
  assign fall_nx = fall_q + (dn_evt ? nbits : '0);
  assign load    = hit && (!msg_valid || msg_ready);
  assign drop    = hit && msg_valid && !msg_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q       <= '0;
      fall_q       <= '0;
      msg_valid    <= 1'b0;
      msg_time     <= '0;
      msg_cnt_rise <= '0;
      msg_cnt_fall <= '0;
      msg_mask     <= '0;
      msg_dir      <= 1'b0;
      msg_lost     <= 1'b0;
    end else begin
      rise_q <= rise_nx;
      fall_q <= fall_nx;
      if (load) begin
        msg_valid    <= 1'b1;
        msg_time     <= ts;
        msg_cnt_rise <= rise_nx;
        msg_cnt_fall <= fall_nx;
        msg_mask     <= hit_mask;
        msg_dir      <= ~exp_bit;
      end else if (msg_ready) begin
        msg_valid <= 1'b0;
      end
      if (drop)
        msg_lost <= 1'b1;
    end
  end

  // R8: a stalled message is frozen
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_time) &&
      $stable(msg_mask) && $stable(msg_cnt_rise) && $stable(msg_cnt_fall)));

  // R9: a dropped mismatch raises the lost flag, which never clears
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> msg_lost);
  p_lost_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_lost |=> msg_lost);

  // R10: accept and new mismatch in one cycle give a fresh message
  p_handoff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && msg_valid && msg_ready) |=> (msg_valid && msg_mask != '0));

  // R6: a 0-to-1 event leaves the 1-to-0 total untouched
  p_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && up_evt) |=> (msg_cnt_fall == $past(fall_q)));
endmodule

// File: rtl/upset_chain_checker.sv
module upset_chain_checker #(
  parameter int unsigned CHAIN_LEN  = 8,
  parameter int unsigned NUM_CHAINS = 12,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned TS_W       = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            pat_sel,
  input  logic [NUM_CHAINS-1:0] chain_dout,
  input  logic                  msg_ready,
  output logic                  chain_din,
  output logic                  chain_srst,
  output logic                  chain_arsr_n,
  output logic                  msg_valid,
  output logic [TS_W-1:0]       msg_time,
  output logic [CNT_W-1:0]      msg_cnt_rise,
  output logic [CNT_W-1:0]      msg_cnt_fall,
  output logic [NUM_CHAINS-1:0] msg_mask,
  output logic                  msg_dir,
  output logic                  msg_lost
);
  logic                  int_rst_n;
  logic                  exp_bit, cmp_en;
  logic [NUM_CHAINS-1:0] hit_mask;
  logic [TS_W-1:0]       ts;

  upchk_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (int_rst_n)
  );

  assign chain_arsr_n = int_rst_n;
  assign chain_srst   = ~int_rst_n;

  upchk_stream_ref #(.CHAIN_LEN(CHAIN_LEN)) u_ref (
    .clk     (clk),
    .rst_n   (int_rst_n),
    .pat_sel (pat_sel),
    .din     (chain_din),
    .exp_bit (exp_bit),
    .cmp_en  (cmp_en)
  );

  always_ff @(posedge clk or negedge int_rst_n) begin
    if (!int_rst_n) ts <= '0;
    else            ts <= ts + 1'b1;
  end

  assign hit_mask = cmp_en ? (chain_dout ^ {NUM_CHAINS{exp_bit}}) : '0;

  upchk_log #(.NUM_CHAINS(NUM_CHAINS), .CNT_W(CNT_W), .TS_W(TS_W)) u_log (
    .clk          (clk),
    .rst_n        (int_rst_n),
    .hit_mask     (hit_mask),
    .exp_bit      (exp_bit),
    .ts           (ts),
    .msg_ready    (msg_ready),
    .msg_valid    (msg_valid),
    .msg_time     (msg_time),
    .msg_cnt_rise (msg_cnt_rise),
    .msg_cnt_fall (msg_cnt_fall),
    .msg_mask     (msg_mask),
    .msg_dir      (msg_dir),
    .msg_lost     (msg_lost)
  );

  // R3: with the window closed and no message pending, none appears
  p_quiet_r3: assert property (@(posedge clk) disable iff (!int_rst_n)
    (!cmp_en && !msg_valid) |=> !msg_valid);

  // R4: a mismatch with a free output yields a message next cycle
  p_report_r4: assert property (@(posedge clk) disable iff (!int_rst_n)
    (cmp_en && (chain_dout != {NUM_CHAINS{exp_bit}}) && !msg_valid) |=> msg_valid);

  // R1: reset state of the message output
  p_reset_r1: assert property (@(posedge clk)
    !int_rst_n |-> (!msg_valid && !msg_lost));
endmodule

// File: tb/tb_upset_chain_checker.sv
module tb_upset_chain_checker;
  localparam int L   = 8;
  localparam int NCH = 12;
  localparam int CW  = 16;
  localparam int TW  = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [1:0]     pat_sel = 2'b00;
  logic           msg_ready = 1'b0;
  logic [NCH-1:0] inj = '0;
  logic [NCH-1:0] dout_w, last_w;
  logic           chain_din, chain_srst, chain_arsr_n;
  logic           msg_valid, msg_dir, msg_lost;
  logic [TW-1:0]  msg_time;
  logic [CW-1:0]  msg_cnt_rise, msg_cnt_fall;
  logic [NCH-1:0] msg_mask;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [CW-1:0] rise_exp = '0, fall_exp = '0;

  always #2 clk = ~clk;

  upset_chain_checker #(.CHAIN_LEN(L), .NUM_CHAINS(NCH), .CNT_W(CW), .TS_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .chain_dout(dout_w),
    .msg_ready(msg_ready), .chain_din(chain_din), .chain_srst(chain_srst),
    .chain_arsr_n(chain_arsr_n), .msg_valid(msg_valid), .msg_time(msg_time),
    .msg_cnt_rise(msg_cnt_rise), .msg_cnt_fall(msg_cnt_fall),
    .msg_mask(msg_mask), .msg_dir(msg_dir), .msg_lost(msg_lost)
  );

  // Chain models: three chains in each of four clear styles
  for (genvar i = 0; i < NCH; i++) begin : g_chain
    logic [L-1:0] q;
    if (i / 3 == 0) begin : g_none
      always_ff @(posedge clk) q <= {q[L-2:0], chain_din};
    end else if (i / 3 == 1) begin : g_sync
      always_ff @(posedge clk)
        if (chain_srst) q <= '0; else q <= {q[L-2:0], chain_din};
    end else if (i / 3 == 2) begin : g_async
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '0; else q <= {q[L-2:0], chain_din};
    end else begin : g_arsr
      always_ff @(posedge clk or negedge chain_arsr_n)
        if (!chain_arsr_n) q <= '0; else q <= {q[L-2:0], chain_din};
    end
    assign last_w[i] = q[L-1];
    assign dout_w[i] = q[L-1] ^ inj[i];
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Flip chain outputs for one cycle; returns the expected direction.
  task automatic inject(input logic [NCH-1:0] m, output logic dir);
    dir = ~last_w[0];
    inj = m;
    if (dir) rise_exp = rise_exp + CW'($countones(m));
    else     fall_exp = fall_exp + CW'($countones(m));
    tick();
    inj = '0;
  endtask

  task automatic pop();
    msg_ready = 1'b1;
    tick();
    msg_ready = 1'b0;
  endtask

  // Vector table: {pat_sel, injected mask}
  localparam logic [13:0] VEC [6] = '{
    {2'b00, 12'h001}, {2'b01, 12'h0C0}, {2'b10, 12'h801},
    {2'b11, 12'h0F0}, {2'b00, 12'h210}, {2'b01, 12'hFFF}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic d;
    logic [TW-1:0] t_a;
    repeat (3) tick();
    // R1: reset state
    chk(msg_valid == 0 && msg_lost == 0, "R1 reset outputs", {msg_valid, msg_lost}, 0);
    chk(chain_srst == 1 && chain_arsr_n == 0, "R1 reset clears", {chain_srst, chain_arsr_n}, 2);
    rst_n = 1'b1;
    tick();
    chk(chain_arsr_n == 0, "R1 release after one edge", chain_arsr_n, 0);
    tick();
    chk(chain_arsr_n == 1 && chain_srst == 0, "R1 release after two edges",
        {chain_srst, chain_arsr_n}, 1);

    // Table walk: R2 stream, R3 fill quiet, R4/R5/R6 reporting
    for (int k = 0; k < 6; k++) begin
      logic [1:0] p;
      logic [NCH-1:0] m;
      bit quiet, stream_ok;
      logic prev;
      p = VEC[k][13:12];
      m = VEC[k][11:0];
      pat_sel = p;
      quiet = 1'b1;
      stream_ok = 1'b1;
      prev = 1'b0;
      for (int c = 0; c < L + 4; c++) begin
        tick();
        if (msg_valid) quiet = 1'b0;
        if (c >= 1) begin
          if (p[1]) begin
            if (c >= 2 && chain_din == prev) stream_ok = 1'b0;
          end else if (chain_din != p[0]) stream_ok = 1'b0;
        end
        prev = chain_din;
      end
      chk(quiet, "R3 no message during fill", msg_valid, 0);
      chk(stream_ok, "R2 pattern stream", p, p);
      inject(m, d);
      chk(msg_valid == 1, "R4 message appears", msg_valid, 1);
      chk(msg_mask == m, "R4 mask", msg_mask, m);
      chk(msg_dir == d, "R5 direction", msg_dir, d);
      chk(msg_cnt_rise == rise_exp, "R6 rise count", msg_cnt_rise, rise_exp);
      chk(msg_cnt_fall == fall_exp, "R6 fall count", msg_cnt_fall, fall_exp);
      pop();
      chk(msg_valid == 0, "R4 message consumed", msg_valid, 0);
    end

    // R7: timestamps five cycles apart
    pat_sel = 2'b00;
    repeat (L + 4) tick();
    inject(12'h002, d);
    t_a = msg_time;
    msg_ready = 1'b1;
    tick();
    msg_ready = 1'b0;
    repeat (3) tick();
    inject(12'h004, d);
    chk(msg_time - t_a == 5, "R7 timestamp delta", msg_time - t_a, 5);

    // R10: accept and new mismatch in the same cycle
    msg_ready = 1'b1;
    inject(12'h100, d);
    msg_ready = 1'b0;
    chk(msg_valid == 1 && msg_mask == 12'h100, "R10 fresh message", msg_mask, 12'h100);
    chk(msg_lost == 0, "R10 no loss", msg_lost, 0);
    chk(msg_cnt_rise == rise_exp, "R10 count", msg_cnt_rise, rise_exp);

    // R8/R9: stall, then a second mismatch is dropped but counted
    t_a = msg_time;
    inject(12'h020, d);
    chk(msg_mask == 12'h100 && msg_time == t_a, "R8 held message", msg_mask, 12'h100);
    chk(msg_lost == 1, "R9 lost flag set", msg_lost, 1);
    pop();
    inject(12'h008, d);
    chk(msg_cnt_rise == rise_exp, "R9 dropped flips counted", msg_cnt_rise, rise_exp);
    chk(msg_lost == 1, "R9 lost flag sticky", msg_lost, 1);

    // R1: reset mid-run with a pending message
    rst_n = 1'b0;
    tick();
    chk(msg_valid == 0 && msg_lost == 0, "R1 reset clears message", {msg_valid, msg_lost}, 0);
    chk(chain_srst == 1, "R1 reset reasserts clears", chain_srst, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule